// File: doc/BRIEF.md
# UART Interrupt Source Arbiter and Identification Register

This block gathers the four interrupt causes of a FIFO-based UART into a single status byte that an interrupt handler reads first. The four causes are receive errors, a receive FIFO that has reached its trigger level, an emptied transmit holding register, and a fully idle transmitter. The byte carries a 3-bit code for the most urgent cause that is both pending and enabled. It also carries an active-low "something pending" bit. Each cause keeps its own clearing rule, driven by bus strobes that mark reads and writes of the neighbouring UART registers.

The serial engine supplies its error pulses, the receive FIFO fill level, the programmed trigger level, and the two transmitter empty flags. The bus side supplies one-cycle strobes for four accesses:
- a read of this identification byte;
- a read of the line status register;
- a read of the receive buffer;
- a write of the transmit holding register.

The byte on `ident_o` is the value returned in the cycle of the read. Clearing takes effect from the next cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset `ident_o` equals 0x41: no source pending, pending flag high.
- R2: `ident_o[7:4]` is always 4'b0100. `ident_o[0]` is 0 exactly when an enabled source is pending. `ident_o[3:1]` is the code of the reported source: 3'b011 line errors, 3'b010 receive data, 3'b001 holding register empty, 3'b111 transmitter empty. It is 3'b000 when nothing is pending. Full bytes are 0x46, 0x44, 0x42, 0x4E and 0x41.
- R3: Priority is fixed. Line errors win over receive data. Receive data wins over both transmit causes. Holding-register-empty wins over transmitter-empty.
- R4: A high level on any bit of `err_flags` (bit 0 overrun, 1 parity, 2 framing, 3 break) latches a line error condition. That condition is reported from the next cycle. A `rd_line` cycle clears it from the next cycle on.
- R5: The receive data condition is reported from the cycle after `rx_level >= rx_trigger`. It is withdrawn in the cycle after `rx_level` falls below `rx_trigger`. It is also withdrawn in the cycle after a `rd_rxbuf` strobe, and comes back one cycle later if the level is still at or above the trigger.
- R6: A 0-to-1 transition of `thr_empty` latches the holding-register-empty condition, and a 0-to-1 transition of `tsr_empty` latches the transmitter-empty condition. Each is reported from the next cycle. A flag that is already high when reset is released raises nothing.
- R7: A `wr_thr` strobe clears both transmit conditions from the next cycle.
- R8: A `rd_ident` strobe clears only a transmit condition whose code is the one shown on `ident_o` in that same cycle. It never clears line errors, receive data, or a transmit condition that is not being reported.
- R9: `src_en` bit 0 masks line errors, bit 1 receive data, bit 2 holding-register-empty and bit 3 transmitter-empty. A masked source neither drives `ident_o[0]` low nor appears in the code. Its latched condition is kept and is reported once the mask bit is set again.
- R10: A set event (an error pulse or an empty-flag rising edge) in the same cycle as a clearing strobe for that source leaves the condition pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 4 | Per-source enables (0 line, 1 receive, 2 holding empty, 3 transmitter empty) |
| err_flags | input | NUM_ERR | Receive error pulses: overrun, parity, framing, break |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive FIFO trigger level |
| thr_empty | input | 1 | Transmit holding register empty flag |
| tsr_empty | input | 1 | Transmit shift register empty flag |
| rd_ident | input | 1 | Read strobe of the identification byte |
| rd_line | input | 1 | Read strobe of the line status register |
| rd_rxbuf | input | 1 | Read strobe of the receive buffer |
| wr_thr | input | 1 | Write strobe of the transmit holding register |
| ident_o | output | 8 | Identification byte |

## Verification
Two clearing collisions matter here.

The first is an identification read that falls in the same cycle as a transmit condition rising. The bench reads while holding-register-empty is shown and transmitter-empty rises. It also reads while transmitter-empty is shown and a new holding-register-empty edge arrives. In each case the bench expects the reported source to go and the new one to remain.

The second is a line status read that coincides with a fresh error pulse. The bench drives both in one vector and expects the line code to persist until a later, clean read clears it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC = 4;

  // Source slots, listed from most to least urgent
  localparam int SRC_LINE = 0;
  localparam int SRC_RDA  = 1;
  localparam int SRC_THRE = 2;
  localparam int SRC_TEMT = 3;

  typedef enum logic [2:0] {
    CODE_NONE = 3'b000,
    CODE_THRE = 3'b001,
    CODE_RDA  = 3'b010,
    CODE_LINE = 3'b011,
    CODE_TEMT = 3'b111
  } irq_code_e;

  localparam logic [3:0] RSVD_NIBBLE = 4'b0100;

  function automatic irq_code_e src_code(input int idx);
    case (idx)
      SRC_LINE: src_code = CODE_LINE;
      SRC_RDA:  src_code = CODE_RDA;
      SRC_THRE: src_code = CODE_THRE;
      SRC_TEMT: src_code = CODE_TEMT;
      default:  src_code = CODE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr #(
  parameter int NUM_ERR = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ERR-1:0] err_i,
  input  logic               clr_i,
  output logic               pend_o
);

  logic [NUM_ERR-1:0] sticky_q, sticky_d;

  always_comb begin
    sticky_d = sticky_q;
    if (clr_i) sticky_d = '0;
    sticky_d = sticky_d | err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  assign pend_o = |sticky_q;

  AST_LSR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_i) |=> pend_o);  // R10
  AST_LSR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(|err_i)) |=> !pend_o);  // R4

endmodule

// File: rtl/uart_irq_rda.sv
module uart_irq_rda #(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trigger_i,
  input  logic             rd_i,
  output logic             pend_o
);

  logic at_trig;
  logic pend_q, pend_d;

  assign at_trig = (level_i >= trigger_i);

  always_comb begin
    pend_d = at_trig & ~rd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_RDA_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i < trigger_i) |=> !pend_o);  // R5
  AST_RDA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> !pend_o);  // R5

endmodule

// File: rtl/uart_irq_txe.sv
module uart_irq_txe (
  input  logic clk,
  input  logic rst_n,
  input  logic empty_i,
  input  logic clr_i,
  output logic pend_o
);

  logic empty_q;
  logic pend_q, pend_d;
  logic rise;

  assign rise = empty_i & ~empty_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (rise)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      empty_q <= empty_i;
      pend_q  <= pend_d;
    end
  end

  assign pend_o = pend_q;

  AST_TXE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_i && !$past(empty_i)) |=> pend_o);  // R6
  AST_TXE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(empty_i && !empty_q)) |=> !pend_o);  // R7

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] grant_o,
  output logic [2:0]      code_o,
  output logic            none_o
);

  logic [NSRC:0] taken;

  assign taken[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign grant_o[g]  = req_i[g] & ~taken[g];
    assign taken[g+1] = taken[g] | req_i[g];
  end

  always_comb begin
    code_o = CODE_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) code_o = src_code(i);
    end
  end

  assign none_o = ~taken[NSRC];

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant_o));  // R3
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int NUM_ERR = 4,
  parameter int LVL_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_en,
  input  logic [NUM_ERR-1:0] err_flags,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [LVL_W-1:0]   rx_trigger,
  input  logic               thr_empty,
  input  logic               tsr_empty,
  input  logic               rd_ident,
  input  logic               rd_line,
  input  logic               rd_rxbuf,
  input  logic               wr_thr,
  output logic [7:0]         ident_o
);

  localparam int NTX = 2;

  logic [NSRC-1:0] pend_raw;
  logic [NSRC-1:0] pend_vis;
  logic [NSRC-1:0] grant;
  logic [2:0]      code;
  logic            none;
  logic [NTX-1:0]  tx_empty;
  logic [NTX-1:0]  tx_clr;

  uart_irq_lsr #(.NUM_ERR(NUM_ERR)) u_lsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_i  (err_flags),
    .clr_i  (rd_line),
    .pend_o (pend_raw[SRC_LINE])
  );

  uart_irq_rda #(.LVL_W(LVL_W)) u_rda (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (rx_level),
    .trigger_i (rx_trigger),
    .rd_i      (rd_rxbuf),
    .pend_o    (pend_raw[SRC_RDA])
  );

  assign tx_empty = {tsr_empty, thr_empty};

  for (genvar t = 0; t < NTX; t++) begin : g_tx
    assign tx_clr[t] = wr_thr | (rd_ident & grant[SRC_THRE + t]);
    uart_irq_txe u_txe (
      .clk     (clk),
      .rst_n   (rst_n),
      .empty_i (tx_empty[t]),
      .clr_i   (tx_clr[t]),
      .pend_o  (pend_raw[SRC_THRE + t])
    );
  end

  assign pend_vis = pend_raw & src_en;

  uart_irq_prio u_prio (
    .req_i   (pend_vis),
    .grant_o (grant),
    .code_o  (code),
    .none_o  (none)
  );

  assign ident_o = {RSVD_NIBBLE, code, none};

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |-> ident_o[0]);  // R9
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_raw[SRC_LINE] && src_en[SRC_LINE]) |-> (ident_o[3:1] == 3'b011));  // R3
  AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && !wr_thr) |=>
      !($fell(pend_raw[SRC_THRE]) && $fell(pend_raw[SRC_TEMT])));  // R8
  AST_READ_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ident && !rd_line && pend_raw[SRC_LINE]) |=> pend_raw[SRC_LINE]);  // R8
  AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !ident_o[0] |-> (ident_o[3:1] != 3'b000));  // R2

endmodule

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

  localparam int NUM_ERR = 4;
  localparam int LVL_W   = 5;

  logic             clk;
  logic             rst_n;
  logic [3:0]       src_en;
  logic [3:0]       err_flags;
  logic [LVL_W-1:0] rx_level;
  logic [LVL_W-1:0] rx_trigger;
  logic             thr_empty, tsr_empty;
  logic             rd_ident, rd_line, rd_rxbuf, wr_thr;
  logic [7:0]       ident_o;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  uart_irq_ident #(.NUM_ERR(NUM_ERR), .LVL_W(LVL_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .err_flags  (err_flags),
    .rx_level   (rx_level),
    .rx_trigger (rx_trigger),
    .thr_empty  (thr_empty),
    .tsr_empty  (tsr_empty),
    .rd_ident   (rd_ident),
    .rd_line    (rd_line),
    .rd_rxbuf   (rd_rxbuf),
    .wr_thr     (wr_thr),
    .ident_o    (ident_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic compare(input logic [7:0] exp, input string tag);
    n_vec++;
    if (ident_o !== exp) begin
      n_fail++;
      $display("FAIL %s: ident_o=0x%02h expected 0x%02h", tag, ident_o, exp);
    end
  endtask

  // Driver: drive one vector at the falling edge, queue the byte expected after the next rising edge
  task automatic drive(input logic [7:0] exp, input string tag);
    sb_item_t it;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
    @(negedge clk);
    err_flags = '0;
    rd_ident  = 1'b0;
    rd_line   = 1'b0;
    rd_rxbuf  = 1'b0;
    wr_thr    = 1'b0;
  endtask

  // Monitor: compare after each rising edge that has a queued expectation
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      compare(it.exp, it.tag);
    end
  end

  initial begin
    rst_n = 1'b0;
    src_en = 4'b1111;
    err_flags = '0;
    rx_level = '0;
    rx_trigger = 5'd4;
    thr_empty = 1'b1;
    tsr_empty = 1'b1;
    rd_ident = 1'b0;
    rd_line = 1'b0;
    rd_rxbuf = 1'b0;
    wr_thr = 1'b0;
    repeat (3) @(negedge clk);
    compare(8'h41, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(8'h41, "R1 after release");

    drive(8'h41, "R6 flags high at reset raise nothing");
    thr_empty = 1'b0; tsr_empty = 1'b0;
    drive(8'h41, "R6 flags falling raise nothing");
    thr_empty = 1'b1;
    drive(8'h42, "R6 holding empty rise");
    tsr_empty = 1'b1;
    drive(8'h42, "R3 holding empty over transmitter empty");
    rd_ident = 1'b1;
    drive(8'h4E, "R8 read clears reported holding empty only");
    wr_thr = 1'b1;
    drive(8'h41, "R7 write clears transmit conditions");

    thr_empty = 1'b0; tsr_empty = 1'b0;
    drive(8'h41, "R6 idle");
    thr_empty = 1'b1;
    drive(8'h42, "R6 holding empty again");
    rd_ident = 1'b1; tsr_empty = 1'b1;
    drive(8'h4E, "R10 read and new transmitter empty same cycle");
    thr_empty = 1'b0;
    drive(8'h4E, "R8 transmitter empty kept");
    rd_ident = 1'b1; thr_empty = 1'b1;
    drive(8'h42, "R10 read of transmitter empty with new holding edge");
    wr_thr = 1'b1; thr_empty = 1'b0;
    drive(8'h41, "R7 write clears");
    thr_empty = 1'b1;
    wr_thr = 1'b1;
    drive(8'h42, "R10 write and holding edge same cycle");
    wr_thr = 1'b1;
    drive(8'h41, "R7 clean write");

    rx_level = 5'd4;
    drive(8'h44, "R5 level reaches trigger");
    rd_rxbuf = 1'b1;
    drive(8'h41, "R5 buffer read withdraws");
    drive(8'h44, "R5 returns while still at trigger");
    rx_level = 5'd3;
    drive(8'h41, "R5 below trigger");
    rx_level = 5'd4; err_flags = 4'b0010;
    drive(8'h46, "R3 line over receive data");
    rd_ident = 1'b1;
    drive(8'h46, "R8 ident read keeps line errors");
    rd_line = 1'b1;
    drive(8'h44, "R4 line read clears");
    rd_line = 1'b1; err_flags = 4'b0001;
    drive(8'h46, "R10 line read with new overrun");
    rd_line = 1'b1;
    drive(8'h44, "R4 clean line read");
    err_flags = 4'b1000;
    drive(8'h46, "R4 break latches");
    rd_line = 1'b1;
    drive(8'h44, "R4 cleared again");
    err_flags = 4'b0100;
    drive(8'h46, "R4 framing latches");
    rd_line = 1'b1;
    drive(8'h44, "R4 framing cleared");

    src_en = 4'b0000; err_flags = 4'b0001;
    drive(8'h41, "R9 all masked");
    src_en = 4'b0010;
    drive(8'h44, "R9 line masked, receive shown");
    src_en = 4'b0001;
    drive(8'h46, "R9 latched line revealed");
    rd_line = 1'b1;
    drive(8'h41, "R9 receive masked after line cleared");
    rx_level = 5'd0; src_en = 4'b1011;
    thr_empty = 1'b0;
    drive(8'h41, "R9 idle");
    thr_empty = 1'b1;
    drive(8'h41, "R9 holding empty masked");
    rd_ident = 1'b1;
    drive(8'h41, "R8 masked source not reported");
    src_en = 4'b1111;
    drive(8'h42, "R8 masked source survived read");
    rx_trigger = 5'd0;
    drive(8'h44, "R2 zero trigger always reached");
    rx_trigger = 5'd31; rx_level = 5'd31;
    drive(8'h44, "R5 full scale level at trigger");
    rx_level = 5'd30;
    drive(8'h42, "R5 one below trigger");
    wr_thr = 1'b1;
    drive(8'h41, "R2 idle byte");

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule